// File: doc/BRIEF.md
# Viewport Outbound Address Translator

This block translates outbound CPU-side addresses into bus addresses using a small set of programmable regions. Each region holds a 64-bit base, a 32-bit limit that extends the upper half of the base, a 64-bit target and a transaction type code. A request address that falls inside an enabled region comes out rebased onto that region's target, tagged with the region's type. A request that falls inside no region comes out unchanged with a miss flag.

Software never addresses a region directly. One selector register picks a direction and a region number. A fixed group of window registers then reads and writes the fields of the selected region. Software may rewrite a region between requests, for example to point it first at a configuration target and then back at I/O. The new contents apply to the very next request.

Top module: `vpat_top`

## Requirements
- R1: After synchronous reset, rsp_valid is 0, the selector reads 0, and every region reads back as disabled with all fields 0.
- R2: The selector sits at offset 0x900. Bit 31 chooses the direction (1 inbound, 0 outbound). The low index bits pick the region. Both read back as written, and all other bits read 0.
- R3: With an outbound region selected, the window reads back what was written. The type is in bits 4:0 at 0x904. Enable is bit 31 and BAR-match mode is bit 30 at 0x908. Base low and high are at 0x90C and 0x910, the limit at 0x914, and target low and high at 0x918 and 0x91C.
- R4: While inbound is selected, every window register reads 0 and window writes leave all regions unchanged.
- R5: A request hits a region when the region is enabled and base <= addr <= {base high, limit}, with both bounds inclusive. On a hit, rsp_addr = target + (addr - base) and rsp_type is the region's type code. The response appears one cycle after req_valid, and rsp_valid follows req_valid with one cycle of delay.
- R6: When several regions hit, the lowest-numbered region supplies the result.
- R7: A request that hits no region returns rsp_miss = 1, rsp_type = 0 and rsp_addr equal to the request address.
- R8: A region whose enable bit is 0 never hits, even when the address lies inside its range.
- R9: A window write takes effect for a request presented in any later cycle.
- R10: A configuration region (type 4 or 5) whose target packs bus in bits 31:24, device in 23:19 and function in 18:16 returns that target unchanged, with the region's type, for a request at its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 64 | CPU-side request address |
| rsp_valid | output | 1 | Translated result is valid |
| rsp_addr | output | 64 | Translated bus address, or the request address on a miss |
| rsp_type | output | 5 | Type code of the matching region (0 on a miss) |
| rsp_miss | output | 1 | No enabled region matched |

## Verification
The translation path is exercised with addresses at the exact lower and upper bounds of a region, inside a region, inside the overlap of two regions, one byte past the last region, and below every region. These cases separate inclusive from exclusive bounds, the priority order, and the rebase arithmetic from a plain pass-through. Directed cases then disable a region that still covers the address and reprogram a region between two requests. A configuration region's packed bus, device and function target is returned intact. Window traffic with inbound selected is checked by switching back to outbound and confirming that nothing changed.

// File: rtl/vpat_pkg.sv
package vpat_pkg;

    localparam int ADDR_W = 64;
    localparam int TYPE_W = 5;

    localparam logic [11:0] OFS_SEL  = 12'h900;
    localparam logic [11:0] OFS_CTL1 = 12'h904;
    localparam logic [11:0] OFS_CTL2 = 12'h908;
    localparam logic [11:0] OFS_BLO  = 12'h90C;
    localparam logic [11:0] OFS_BHI  = 12'h910;
    localparam logic [11:0] OFS_LIM  = 12'h914;
    localparam logic [11:0] OFS_TLO  = 12'h918;
    localparam logic [11:0] OFS_THI  = 12'h91C;

    typedef enum logic [TYPE_W-1:0] {
        KIND_MEM  = 5'd0,
        KIND_IO   = 5'd2,
        KIND_CFG0 = 5'd4,
        KIND_CFG1 = 5'd5
    } kind_e;

    typedef struct packed {
        logic              en;
        logic              bar_mode;
        logic [TYPE_W-1:0] kind;
        logic [ADDR_W-1:0] base;
        logic [31:0]       limit;
        logic [ADDR_W-1:0] tgt;
    } region_t;

    typedef struct packed {
        logic              miss;
        logic [TYPE_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
    } xlat_t;

    function automatic logic [31:0] window_view(input region_t r, input logic [11:0] ofs);
        logic [31:0] v;
        case (ofs)
            OFS_CTL1: v = {{(32-TYPE_W){1'b0}}, r.kind};
            OFS_CTL2: v = {r.en, r.bar_mode, 30'd0};
            OFS_BLO:  v = r.base[31:0];
            OFS_BHI:  v = r.base[63:32];
            OFS_LIM:  v = r.limit;
            OFS_TLO:  v = r.tgt[31:0];
            OFS_THI:  v = r.tgt[63:32];
            default:  v = 32'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vpat_regfile.sv
module vpat_regfile
    import vpat_pkg::*;
#(
    parameter int N_REG = 2,
    parameter int IDX_W = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [11:0]             cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output region_t [N_REG-1:0]     regs
);

    logic             sel_in;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_ok;

    assign sel_ok = !sel_in && (int'(sel_idx) < N_REG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_in  <= 1'b0;
            sel_idx <= '0;
            regs    <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == OFS_SEL) begin
                sel_in  <= cfg_wdata[31];
                sel_idx <= cfg_wdata[IDX_W-1:0];
            end else if (sel_ok) begin
                case (cfg_addr)
                    OFS_CTL1: regs[sel_idx].kind <= cfg_wdata[TYPE_W-1:0];
                    OFS_CTL2: begin
                        regs[sel_idx].en       <= cfg_wdata[31];
                        regs[sel_idx].bar_mode <= cfg_wdata[30];
                    end
                    OFS_BLO: regs[sel_idx].base[31:0]  <= cfg_wdata;
                    OFS_BHI: regs[sel_idx].base[63:32] <= cfg_wdata;
                    OFS_LIM: regs[sel_idx].limit       <= cfg_wdata;
                    OFS_TLO: regs[sel_idx].tgt[31:0]   <= cfg_wdata;
                    OFS_THI: regs[sel_idx].tgt[63:32]  <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (cfg_addr == OFS_SEL)
            cfg_rdata = {sel_in, {(31-IDX_W){1'b0}}, sel_idx};
        else if (sel_ok)
            cfg_rdata = window_view(regs[sel_idx], cfg_addr);
        else
            cfg_rdata = 32'd0;
    end

    // R4: window writes with inbound selected change no region
    assert_inbound_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && sel_in && cfg_addr != OFS_SEL) |=> $stable(regs));

    // R2: selector write is visible at the next cycle
    assert_sel_written_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == OFS_SEL) |=> (sel_in == $past(cfg_wdata[31])));

endmodule

// File: rtl/vpat_match.sv
module vpat_match
    import vpat_pkg::*;
#(
    parameter int N_REG = 2,
    parameter int IDX_W = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  region_t [N_REG-1:0] regs,
    input  logic [ADDR_W-1:0]   addr,
    output xlat_t               res
);

    logic [N_REG-1:0] hit;
    logic [N_REG-1:0] grant;
    logic [IDX_W-1:0] win;

    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        logic [ADDR_W-1:0] top_addr;
        assign top_addr = {regs[g].base[ADDR_W-1:32], regs[g].limit};
        assign hit[g] = regs[g].en && (addr >= regs[g].base) && (addr <= top_addr);
    end

    always_comb begin
        win   = '0;
        grant = '0;
        for (int i = N_REG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win   = IDX_W'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (|hit) begin
            res.miss = 1'b0;
            res.kind = regs[win].kind;
            res.addr = regs[win].tgt + (addr - regs[win].base);
        end else begin
            res.miss = 1'b1;
            res.kind = '0;
            res.addr = addr;
        end
    end

    // R6: at most one region is chosen and only one that hits
    assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~hit) == '0));

    // R8: a disabled region never hits
    for (genvar g = 0; g < N_REG; g++) begin : g_chk
        assert_disabled_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
            !regs[g].en |-> !hit[g]);
    end

endmodule

// File: rtl/vpat_top.sv
module vpat_top
    import vpat_pkg::*;
#(
    parameter int N_REG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_addr,
    output logic [4:0]        rsp_type,
    output logic              rsp_miss
);

    localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

    region_t [N_REG-1:0] regs;
    xlat_t               comb_res;

    vpat_regfile #(.N_REG(N_REG), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .regs(regs)
    );

    vpat_match #(.N_REG(N_REG), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst(rst), .regs(regs), .addr(req_addr), .res(comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_type  <= '0;
            rsp_miss  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr <= comb_res.addr;
                rsp_type <= comb_res.kind;
                rsp_miss <= comb_res.miss;
            end
        end
    end

    // R1: response valid is low right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R5: valid follows the request by one cycle
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_valid_drops_R5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R7: a miss passes the address through with type zero
    assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(|comb_res.kind) && comb_res.miss)
            |=> (rsp_miss && rsp_type == 5'd0 && rsp_addr == $past(req_addr)));

endmodule

// File: tb/tb_vpat_top.sv
module tb_vpat_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [4:0]  rsp_type;
    logic        rsp_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpat_top #(.N_REG(2)) dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_miss(rsp_miss)
    );

    // request address, expected address, expected type, expected miss
    localparam logic [133:0] VEC [NVEC] = '{
        {64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 5'd0, 1'b0},
        {64'h0000_0001_0000_FFFF, 64'h0000_0000_8000_FFFF, 5'd0, 1'b0},
        {64'h0000_0001_0000_8000, 64'h0000_0000_8000_8000, 5'd0, 1'b0},
        {64'h0000_0001_0001_0000, 64'h0000_0000_2000_8000, 5'd2, 1'b0},
        {64'h0000_0001_0001_7FFF, 64'h0000_0000_2000_FFFF, 5'd2, 1'b0},
        {64'h0000_0001_0001_8000, 64'h0000_0001_0001_8000, 5'd0, 1'b1},
        {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 5'd0, 1'b1},
        {64'h0000_0001_0000_1234, 64'h0000_0000_8000_1234, 5'd0, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic xlat(input logic [63:0] a, input string req,
                        input logic [63:0] ea, input logic [4:0] et, input logic em);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 64'(rsp_valid), 64'd1);
        check({req, " addr"}, rsp_addr, ea);
        check({req, " type"}, 64'(rsp_type), 64'(et));
        check({req, " miss"}, 64'(rsp_miss), 64'(em));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        rd(12'h900, d); check("R1 selector", 64'(d), 64'd0);
        rd(12'h908, d); check("R1 region0 ctl2", 64'(d), 64'd0);
        rd(12'h90C, d); check("R1 region0 base", 64'(d), 64'd0);
        wr(12'h900, 32'h1);
        rd(12'h908, d); check("R1 region1 ctl2", 64'(d), 64'd0);

        // R2 selector readback
        wr(12'h900, 32'hFFFF_FFFF);
        rd(12'h900, d); check("R2 selector bits", 64'(d), 64'h8000_0001);

        // program region 0: memory
        wr(12'h900, 32'h0);
        wr(12'h904, 32'd0);
        wr(12'h90C, 32'h0000_0000); wr(12'h910, 32'h1);
        wr(12'h914, 32'h0000_FFFF);
        wr(12'h918, 32'h8000_0000); wr(12'h91C, 32'h0);
        wr(12'h908, 32'h8000_0000);
        // program region 1: I/O, overlapping the top of region 0
        wr(12'h900, 32'h1);
        wr(12'h904, 32'd2);
        wr(12'h90C, 32'h0000_8000); wr(12'h910, 32'h1);
        wr(12'h914, 32'h0001_7FFF);
        wr(12'h918, 32'h2000_0000); wr(12'h91C, 32'h0);
        wr(12'h908, 32'hC000_0000);

        // R3 window readback of region 1
        rd(12'h904, d); check("R3 type", 64'(d), 64'd2);
        rd(12'h908, d); check("R3 ctl2 enable+bar", 64'(d), 64'hC000_0000);
        rd(12'h90C, d); check("R3 base lo", 64'(d), 64'h0000_8000);
        rd(12'h910, d); check("R3 base hi", 64'(d), 64'h1);
        rd(12'h914, d); check("R3 limit", 64'(d), 64'h0001_7FFF);
        rd(12'h918, d); check("R3 target lo", 64'(d), 64'h2000_0000);

        // R5 R6 R7 vector walk
        for (int i = 0; i < NVEC; i++) begin
            xlat(VEC[i][133:70], $sformatf("R5/R6/R7 vector %0d", i),
                 VEC[i][69:6], VEC[i][5:1], VEC[i][0]);
        end
        @(negedge clk);
        check("R5 valid drops", 64'(rsp_valid), 64'd0);

        // R4 inbound: reads zero, writes ignored
        wr(12'h900, 32'h8000_0001);
        rd(12'h918, d); check("R4 inbound read", 64'(d), 64'd0);
        wr(12'h918, 32'hDEAD_BEEF);
        wr(12'h908, 32'h0);
        wr(12'h900, 32'h1);
        rd(12'h918, d); check("R4 target unchanged", 64'(d), 64'h2000_0000);
        rd(12'h908, d); check("R4 enable unchanged", 64'(d), 64'hC000_0000);

        // R8 disabled region does not hit
        wr(12'h908, 32'h0);
        xlat(64'h0000_0001_0001_0000, "R8 disabled", 64'h0000_0001_0001_0000, 5'd0, 1'b1);

        // R10 config region returns packed target at base
        wr(12'h900, 32'h0);
        wr(12'h904, 32'd4);
        wr(12'h918, 32'h032A_0000);
        xlat(64'h0000_0001_0000_0000, "R10 cfg0 target", 64'h0000_0000_032A_0000, 5'd4, 1'b0);
        wr(12'h904, 32'd5);
        xlat(64'h0000_0001_0000_0000, "R10 cfg1 type", 64'h0000_0000_032A_0000, 5'd5, 1'b0);

        // R9 switch back to I/O for the next request
        wr(12'h904, 32'd2);
        wr(12'h918, 32'h0000_4000);
        xlat(64'h0000_0001_0000_0010, "R9 reprogrammed", 64'h0000_0000_0000_4010, 5'd2, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule